// File: doc/BRIEF.md
# Multi-Timer Control Hub

This block gathers six counter channels behind one 32-bit APB slave and gives software one point of control over all of them. A single control register holds a software gate and a count-enable bit for every channel, so one write starts or stops any set of channels on the same clock edge. A write-one pulse register makes several channels capture their running count at the same instant. Per-channel selectors route any one of sixteen external inputs to each channel's external gate and to its two external capture events.

Each channel is a plain up-counter with a capture register. It counts on every clock while its enable is set and its gate is high. The gate is the OR of the software gate bit and the selected external gate input. External inputs pass through a two-flop synchroniser. A rising edge on either selected event input captures that channel's count, as does a software trigger. Registers sit at fixed word offsets on an 8-bit address: 0x00 control, 0x04 trigger, 0x10+4n selectors, 0x40+4n counts, 0x60+4n captures.

Top module: `multi_timer_hub`

## Requirements
- R1: After reset every counter, capture register, control bit and selector field reads 0, PREADY is 1 and PSLVERR is 0.
- R2: A write whose PSTRB is not 4'hF changes no register.
- R3: In the control register at 0x00, bits [5:0] are the software gates and bits [13:8] are the count enables. One write to it updates every channel on the same clock edge, so channels started and stopped by the same writes hold equal counts.
- R4: A channel's counter rises by exactly one per clock while its enable and its effective gate are both 1. Otherwise it holds its value.
- R5: When a control write clears a channel's enable, that channel's software gate keeps its previous value, whatever the written gate bit is.
- R6: When a control write sets a previously cleared enable together with a new gate value, the new gate is stored and governs counting from the next clock.
- R7: Writing 1 to bit n of the trigger register at 0x04 captures channel n's counter into its capture register (0x60+4n). All channels set in one write capture on the same cycle.
- R8: The trigger register always reads 0.
- R9: The selector at 0x10+4n has three 4-bit fields: [3:0] for the gate, [11:8] for event 1 and [19:16] for event 2. A gate field of k makes external input k, after synchronisation, act as channel n's external gate.
- R10: A synchronised rising edge on the input chosen by either event field captures that channel's count. Channels that do not select that input keep their capture value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes; only 4'hF writes |
| prdata | output | 32 | APB read data, valid during access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 16 | Asynchronous external inputs |

## Verification
A register write takes effect on the edge that completes its access phase. Count-enable and gate changes therefore start or stop counting from the following edge. A software trigger produces its internal pulse one edge after the write and loads the capture one edge after that. An external event needs two synchroniser edges and one capture edge, three in all. The bench drives inputs one time unit after an edge and samples in the access phase of later reads. It waits at least six cycles before it checks anything that passes through the synchroniser. Where an exact count would depend on write latency, it compares channels with each other or compares two reads of the same counter.

// File: rtl/thub_pkg.sv
package thub_pkg;
    localparam int NT     = 6;              // timer channels
    localparam int CW     = 32;             // counter width
    localparam int XW     = 16;             // external inputs
    localparam int SW     = $clog2(XW);     // selector field width
    localparam int AW     = 8;              // address width
    localparam int DW     = 32;             // data width
    localparam int EN_LSB = 8;              // enable field position in control word
    localparam int E1_LSB = 8;              // event-1 selector position
    localparam int E2_LSB = 16;             // event-2 selector position

    localparam logic [AW-1:0] A_CTRL = 8'h00;
    localparam logic [AW-1:0] A_TRIG = 8'h04;
    localparam int            A_SEL  = 'h10;
    localparam int            A_CNT  = 'h40;
    localparam int            A_CAP  = 'h60;

    typedef logic [NT-1:0][SW-1:0] sel_arr_t;
    typedef logic [NT-1:0][CW-1:0] cnt_arr_t;

    typedef struct packed {
        logic [NT-1:0] gate;
        logic [NT-1:0] en;
        logic [NT-1:0] trig;
        sel_arr_t      sel_g;
        sel_arr_t      sel_1;
        sel_arr_t      sel_2;
    } regs_t;
endpackage

// File: rtl/thub_regs.sv
module thub_regs
    import thub_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [3:0]    pstrb,
    output logic [DW-1:0] prdata,
    input  cnt_arr_t      cnt,
    input  cnt_arr_t      cap,
    output regs_t         regs
);
    regs_t r_d, r_q;
    logic  wr_any, wr_ok;

    assign wr_any = psel && penable && pwrite;
    assign wr_ok  = wr_any && (pstrb == 4'hF);

    always_comb begin
        r_d      = r_q;
        r_d.trig = '0;
        if (wr_ok) begin
            if (paddr == A_CTRL) begin
                for (int i = 0; i < NT; i++) begin
                    r_d.en[i] = pwdata[EN_LSB + i];
                    if (r_q.en[i] && !pwdata[EN_LSB + i])
                        r_d.gate[i] = r_q.gate[i];
                    else
                        r_d.gate[i] = pwdata[i];
                end
            end
            if (paddr == A_TRIG)
                r_d.trig = pwdata[NT-1:0];
            for (int i = 0; i < NT; i++) begin
                if (paddr == AW'(A_SEL + 4 * i)) begin
                    r_d.sel_g[i] = pwdata[SW-1:0];
                    r_d.sel_1[i] = pwdata[E1_LSB +: SW];
                    r_d.sel_2[i] = pwdata[E2_LSB +: SW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        prdata = '0;
        if (paddr == A_CTRL) begin
            prdata[NT-1:0]       = r_q.gate;
            prdata[EN_LSB +: NT] = r_q.en;
        end
        for (int i = 0; i < NT; i++) begin
            if (paddr == AW'(A_SEL + 4 * i)) begin
                prdata[SW-1:0]       = r_q.sel_g[i];
                prdata[E1_LSB +: SW] = r_q.sel_1[i];
                prdata[E2_LSB +: SW] = r_q.sel_2[i];
            end
            if (paddr == AW'(A_CNT + 4 * i)) prdata = DW'(cnt[i]);
            if (paddr == AW'(A_CAP + 4 * i)) prdata = DW'(cap[i]);
        end
    end

    assign regs = r_q;

    // R2: a partial-strobe write leaves control and selectors untouched
    a_r2_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && pstrb != 4'hF) |=> ($stable(r_q.gate) && $stable(r_q.en)
                                        && $stable(r_q.sel_g) && $stable(r_q.sel_1)));
    // R5: gates of channels being disabled keep their old value
    a_r5_gate_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && paddr == A_CTRL) |=>
        ((r_q.gate & ~r_q.en & $past(r_q.en)) == ($past(r_q.gate) & ~r_q.en & $past(r_q.en))));
    // R8: trigger pulse lasts one cycle only
    a_r8_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|r_q.trig) |=> (r_q.trig == '0));
endmodule

// File: rtl/thub_insync.sv
module thub_insync
    import thub_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] ext_in,
    output logic [XW-1:0] lvl,
    output logic [XW-1:0] rise
);
    typedef struct packed {
        logic [XW-1:0] s1;
        logic [XW-1:0] s2;
        logic [XW-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1   = ext_in;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.s2;
    assign rise = s_q.s2 & ~s_q.prev;

    // R10: a reported edge was low on the cycle before
    a_r10_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/thub_channel.sv
module thub_channel
    import thub_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sw_gate,
    input  logic          ext_gate,
    input  logic          cap_req,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cap
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
    } ch_t;

    ch_t  c_d, c_q;
    logic run;

    assign run = en && (sw_gate || ext_gate);

    always_comb begin
        c_d = c_q;
        if (run)     c_d.cnt = c_q.cnt + CW'(1);
        if (cap_req) c_d.cap = c_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
    assign cap = c_q.cap;

    // R4: advance by one while running
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (c_q.cnt == $past(c_q.cnt) + CW'(1)));
    // R4: hold while stopped
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(c_q.cnt));
    // R7: capture loads the count present on the request cycle
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req |=> (c_q.cap == $past(c_q.cnt)));
endmodule

// File: rtl/multi_timer_hub.sv
module multi_timer_hub
    import thub_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [7:0]  paddr,
    input  logic [31:0] pwdata,
    input  logic [3:0]  pstrb,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic [15:0] ext_in
);
    regs_t         regs;
    cnt_arr_t      cnt, cap;
    logic [XW-1:0] lvl, rise;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    thub_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pstrb   (pstrb),
        .prdata  (prdata),
        .cnt     (cnt),
        .cap     (cap),
        .regs    (regs)
    );

    thub_insync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_in),
        .lvl    (lvl),
        .rise   (rise)
    );

    for (genvar g = 0; g < NT; g++) begin : g_ch
        logic ext_gate, cap_req;
        assign ext_gate = lvl[regs.sel_g[g]];
        assign cap_req  = regs.trig[g] | rise[regs.sel_1[g]] | rise[regs.sel_2[g]];

        thub_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (regs.en[g]),
            .sw_gate  (regs.gate[g]),
            .ext_gate (ext_gate),
            .cap_req  (cap_req),
            .cnt      (cnt[g]),
            .cap      (cap[g])
        );
    end
endmodule

// File: tb/multi_timer_hub_test.sv
module multi_timer_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [15:0] ext_in = '0;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 8 ns period

    multi_timer_hub uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_true(input string req, input bit ok, input logic [31:0] act);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=condition", req, act);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; pstrb = s;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        #1 d = prdata;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pready", {31'd0, pready}, 32'd1);
        check("R1 pslverr", {31'd0, pslverr}, 32'd0);
        rd(8'h00, v); check("R1 ctrl", v, 32'd0);
        rd(8'h14, v); check("R1 selector", v, 32'd0);
        rd(8'h40, v); check("R1 count0", v, 32'd0);
        rd(8'h74, v); check("R1 capture5", v, 32'd0);
    endtask

    task automatic t_strobe();
        logic [31:0] v;
        wr(8'h00, 32'h0000_3F3F, 4'h3);
        wr(8'h10, 32'h0000_0005, 4'h1);
        rd(8'h00, v); check("R2 ctrl partial write", v, 32'd0);
        rd(8'h10, v); check("R2 sel partial write", v, 32'd0);
        rd(8'h40, v); check("R2 count0 still idle", v, 32'd0);
    endtask

    task automatic t_sync_start();
        logic [31:0] c0, v, a, b;
        wr(8'h00, 32'h0000_3F3F);
        idle(20);
        wr(8'h00, 32'h0000_3F00);   // gates off, enables stay
        rd(8'h40, c0);
        check_true("R3 count0 advanced", c0 > 32'd10, c0);
        for (int i = 1; i < 6; i++) begin
            rd(8'(8'h40 + 4 * i), v);
            check("R3 equal counts", v, c0);
        end
        rd(8'h40, a); idle(5); rd(8'h40, b);
        check("R4 hold when gate low", b, a);
        wr(8'h04, 32'h0000_003F);
        for (int i = 0; i < 6; i++) begin
            rd(8'(8'h60 + 4 * i), v);
            check("R7 capture all", v, c0);
        end
        rd(8'h04, v); check("R8 trigger reads 0", v, 32'd0);
    endtask

    task automatic t_gate_rules();
        logic [31:0] v, a, b;
        wr(8'h00, 32'h0000_3F3F);
        wr(8'h00, 32'h0000_0000);   // disable and try to drop gates
        rd(8'h00, v); check("R5 gate kept on disable", v, 32'h0000_003F);
        rd(8'h40, a); idle(4); rd(8'h40, b);
        check("R4 hold when disabled", b, a);
        wr(8'h00, 32'h0000_3F00);   // enable with gates changed to 0
        rd(8'h00, v); check("R6 new gate stored on enable", v, 32'h0000_3F00);
        rd(8'h40, a); idle(4); rd(8'h40, b);
        check("R6 new gate 0 stops count", b, a);
        wr(8'h00, 32'h0000_0000);
        wr(8'h00, 32'h0000_0101);   // enable with gate 0->1 on channel 0
        wr(8'h00, 32'h0000_0100);
        rd(8'h40, v);
        check_true("R6 new gate 1 counts", v > b, v);
        wr(8'h00, 32'h0000_0000);
    endtask

    task automatic t_ext_gate();
        logic [31:0] a, b, c, d, v;
        wr(8'h18, 32'h0000_0007);   // channel 2 gate <- input 7
        rd(8'h18, v); check("R9 selector readback", v, 32'h0000_0007);
        wr(8'h00, 32'h0000_0C00);   // enable channels 2 and 3, no sw gate
        ext_in[7] = 1'b1;
        idle(6);
        rd(8'h48, a); rd(8'h4C, c); idle(5); rd(8'h48, b); rd(8'h4C, d);
        check_true("R9 ext gate drives channel 2", b > a, b);
        check("R9 unselected channel 3 holds", d, c);
        ext_in[7] = 1'b0;
        idle(6);
        rd(8'h48, a); idle(5); rd(8'h48, b);
        check("R9 ext gate low holds", b, a);
        wr(8'h00, 32'h0000_0000);
    endtask

    task automatic t_ext_event();
        logic [31:0] c1, c4, k1, k4, v;
        wr(8'h00, 32'h0000_1212);
        idle(7);
        wr(8'h00, 32'h0000_0000);   // stopped, counts now differ from captures
        wr(8'h14, 32'h0000_0900);   // channel 1 event-1 <- input 9
        wr(8'h20, 32'h000C_0000);   // channel 4 event-2 <- input 12
        rd(8'h44, c1); rd(8'h50, c4); rd(8'h70, k4);
        ext_in[9] = 1'b1; idle(6); ext_in[9] = 1'b0; idle(4);
        rd(8'h64, v); check("R10 event1 capture", v, c1);
        rd(8'h70, v); check("R10 other channel keeps capture", v, k4);
        rd(8'h64, k1);
        ext_in[12] = 1'b1; idle(6); ext_in[12] = 1'b0; idle(4);
        rd(8'h70, v); check("R10 event2 capture", v, c4);
        rd(8'h64, v); check("R10 channel 1 unaffected", v, k1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_strobe();
        t_sync_start();
        t_gate_rules();
        t_ext_gate();
        t_ext_event();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule